// File: doc/BRIEF.md
# Multi-Line Transmit Byte Fetcher

This block is the output side of a sixteen-line serial multiplexer. Software picks one line through a small index field in a control word. That line's memory pointer and length counter then appear behind a shared pair of register slots. Software starts a line by setting that line's bit in an active mask.

The fetcher visits the active lines in rotating order and reads one byte per visit through a request/acknowledge memory port. It hands each byte, tagged with its line number, to a downstream stream. For each line it advances the pointer and steps the counter up toward zero. When the counter reaches zero, hardware drops the line's active bit and flags a transmit event. A read that is never acknowledged marks a memory fault and retires the line.

The outgoing byte stream is valid/ready. A byte stays on `out_data`/`out_line` with `out_valid` high until `out_ready` is seen high at a clock edge. No new memory read starts while a byte is waiting, so back-pressure stops fetching completely. The memory port holds `mem_req` and `mem_addr` until `mem_ack`, or until the timeout.

Top module: `txdma_seq`

## Requirements
- R1: `reg_sel` selects a register: 0 is control, 1 is pointer, 2 is counter, 3 is active mask. Control bits [3:0] pick the line whose pointer (low 16 bits) and counter are read and written through slots 1 and 2. Each line keeps its own pointer and counter.
- R2: Writing the pointer slot stores `{control[5:4], wdata[15:0]}`, so control bits 5:4 become pointer bits 17:16 on `mem_addr`.
- R3: The counter is loaded with the negated byte count and rises by one per fetched byte. The fetch that moves it from all-ones to zero clears the line's active bit and sets the transmit flag (control bit 15).
- R4: A granted line raises `mem_req` with `mem_addr` equal to its pointer. Each acknowledge advances that pointer by one and the counter by one.
- R5: A fetched byte appears on the output one cycle after its acknowledge. It holds stable until accepted. `mem_req` stays low while a byte waits.
- R6: Grants rotate. The next line served is the first active line after the last one granted, counting upward with wraparound. After reset, line 0 ranks first.
- R7: `irq` equals transmit flag AND enable (control bit 13). Writing control with bit 15 at 0 clears the flag. Writing it with bit 15 at 1 leaves the flag as it is.
- R8: Writing all-ones to a busy line's counter ends that line after one more byte. The pointer then reads back the address just past the last byte sent.
- R9: A request without acknowledge for 32 cycles ends. It sets the fault bit (control bit 10), clears the line's active bit and outputs no byte. Writing control with bit 8 at 1 clears the fault bit.
- R10: Writing the active mask only sets bits. Zero bits in the written word leave active lines running.
- R11: After reset all registers read zero, and `mem_req`, `out_valid` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register slot for write and read |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the slot on `reg_sel` |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 18 | Byte address of the request |
| mem_ack | input | 1 | Memory read acknowledge |
| mem_rdata | input | 8 | Memory data, valid with `mem_ack` |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the byte |
| out_line | output | 4 | Line the byte belongs to |
| out_data | output | 8 | Output byte |
| irq | output | 1 | Transmit interrupt |

## Verification
The bench targets the count boundary where all-ones steps to zero. An off-by-one there would send one byte too many or too few, and would raise the transmit flag on the wrong fetch. It starts three lines at once under random back-pressure to expose a rotation that restarts at line 0 or skips a line after a neighbour retires. It cuts a long transfer with an all-ones counter write and checks the pointer left behind. It lets a request starve to check the exact 32-cycle timeout, that no byte slips out, and that the fault bit clears only on its own clear bit. It also writes zeros to the active mask mid-transfer, which a design that loads the mask instead of OR-ing it would take as a stop.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_ACT  = 2'd3
  } regsel_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_FETCH = 1'b1
  } fsm_e;

  localparam int CTL_TI    = 15;
  localparam int CTL_TIE   = 13;
  localparam int CTL_NXM   = 10;
  localparam int CTL_NXCLR = 8;
  localparam int CTL_EXT   = 4;
endpackage

// File: rtl/txdma_rr_arb.sv
module txdma_rr_arb #(
  parameter int N  = 16,
  parameter int LW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [LW-1:0] last,
  output logic          any,
  output logic [LW-1:0] grant
);
  // scan downward so the closest line after 'last' is written last and wins
  always_comb begin
    any   = 1'b0;
    grant = '0;
    for (int i = N; i >= 1; i--) begin
      int idx;
      idx = (int'(last) + i) % N;
      if (req[idx]) begin
        any   = 1'b1;
        grant = LW'(idx);
      end
    end
  end
endmodule

// File: rtl/txdma_line_regs.sv
module txdma_line_regs #(
  parameter int N  = 16,
  parameter int AW = 18,
  parameter int CW = 16,
  parameter int LW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we_addr,
  input  logic          host_we_cnt,
  input  logic [LW-1:0] host_line,
  input  logic [AW-1:0] host_addr_d,
  input  logic [CW-1:0] host_cnt_d,
  input  logic          step,
  input  logic [LW-1:0] step_line,
  output logic [15:0]   host_addr_q,
  output logic [CW-1:0] host_cnt_q,
  output logic [AW-1:0] fetch_addr_q,
  output logic [CW-1:0] fetch_cnt_q
);
  logic [AW-1:0] ptr [N];
  logic [CW-1:0] cnt [N];

  // host write has priority over the hardware step on the same line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        ptr[i] <= '0;
        cnt[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (host_we_addr && host_line == LW'(i))
          ptr[i] <= host_addr_d;
        else if (step && step_line == LW'(i))
          ptr[i] <= ptr[i] + 1'b1;
        if (host_we_cnt && host_line == LW'(i))
          cnt[i] <= host_cnt_d;
        else if (step && step_line == LW'(i))
          cnt[i] <= cnt[i] + 1'b1;
      end
    end
  end

  assign host_addr_q  = ptr[host_line][15:0];
  assign host_cnt_q   = cnt[host_line];
  assign fetch_addr_q = ptr[step_line];
  assign fetch_cnt_q  = cnt[step_line];
endmodule

// File: rtl/txdma_fetch_fsm.sv
module txdma_fetch_fsm
  import txdma_pkg::*;
#(
  parameter int N   = 16,
  parameter int TMO = 32,
  parameter int LW  = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  active,
  input  logic          out_busy,
  input  logic          mem_ack,
  output logic          mem_req,
  output logic [LW-1:0] line,
  output logic          done,
  output logic          tmo
);
  localparam int TW = $clog2(TMO);

  fsm_e          st;
  logic [LW-1:0] last;
  logic [TW-1:0] tcnt;
  logic          any;
  logic [LW-1:0] grant;

  txdma_rr_arb #(.N(N), .LW(LW)) u_arb (
    .req   (active),
    .last  (last),
    .any   (any),
    .grant (grant)
  );

  assign mem_req = (st == ST_FETCH);
  assign done    = mem_req && mem_ack;
  assign tmo     = mem_req && !mem_ack && (tcnt == TW'(TMO - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      line <= '0;
      last <= LW'(N - 1);
      tcnt <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (!out_busy && any) begin
            st   <= ST_FETCH;
            line <= grant;
            last <= grant;
            tcnt <= '0;
          end
        end
        default: begin
          if (mem_ack || tmo) st <= ST_IDLE;
          else                tcnt <= tcnt + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/txdma_seq.sv
module txdma_seq
  import txdma_pkg::*;
#(
  parameter int NLINES = 16,
  parameter int EXTW   = 2,
  parameter int CW     = 16,
  parameter int DW     = 8,
  parameter int TMO    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic              mem_req,
  output logic [16+EXTW-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [DW-1:0]     mem_rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [$clog2(NLINES)-1:0] out_line,
  output logic [DW-1:0]     out_data,
  output logic              irq
);
  localparam int LW = $clog2(NLINES);
  localparam int AW = 16 + EXTW;

  logic [LW-1:0]     sel_q;
  logic [EXTW-1:0]   ext_q;
  logic              tie_q, ti_q, nxm_q;
  logic [NLINES-1:0] active_q;
  logic [NLINES-1:0] clr_mask;

  logic          we_ctrl, we_addr, we_cnt, we_act;
  logic [15:0]   addr_host;
  logic [CW-1:0] cnt_host, cnt_fetch;
  logic [LW-1:0] fline;
  logic          done, tmo, last_b;

  assign we_ctrl = reg_we && (reg_sel == SEL_CTRL);
  assign we_addr = reg_we && (reg_sel == SEL_ADDR);
  assign we_cnt  = reg_we && (reg_sel == SEL_CNT);
  assign we_act  = reg_we && (reg_sel == SEL_ACT);

  txdma_line_regs #(.N(NLINES), .AW(AW), .CW(CW), .LW(LW)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_we_addr (we_addr),
    .host_we_cnt  (we_cnt),
    .host_line    (sel_q),
    .host_addr_d  ({ext_q, reg_wdata}),
    .host_cnt_d   (reg_wdata[CW-1:0]),
    .step         (done),
    .step_line    (fline),
    .host_addr_q  (addr_host),
    .host_cnt_q   (cnt_host),
    .fetch_addr_q (mem_addr),
    .fetch_cnt_q  (cnt_fetch)
  );

  txdma_fetch_fsm #(.N(NLINES), .TMO(TMO), .LW(LW)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active_q),
    .out_busy (out_valid),
    .mem_ack  (mem_ack),
    .mem_req  (mem_req),
    .line     (fline),
    .done     (done),
    .tmo      (tmo)
  );

  assign last_b   = done && (cnt_fetch == '1);
  assign clr_mask = (last_b || tmo) ? (NLINES'(1) << fline) : '0;

  // control and status
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      ext_q  <= '0;
      tie_q  <= 1'b0;
      ti_q   <= 1'b0;
      nxm_q  <= 1'b0;
    end else begin
      if (we_ctrl) begin
        sel_q <= reg_wdata[LW-1:0];
        ext_q <= reg_wdata[CTL_EXT +: EXTW];
        tie_q <= reg_wdata[CTL_TIE];
      end
      if (last_b)                             ti_q <= 1'b1;
      else if (we_ctrl && !reg_wdata[CTL_TI]) ti_q <= 1'b0;
      if (tmo)                                   nxm_q <= 1'b1;
      else if (we_ctrl && reg_wdata[CTL_NXCLR])  nxm_q <= 1'b0;
    end
  end

  // active mask: hardware clears, host only sets
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= '0;
    else        active_q <= (active_q & ~clr_mask) |
                            (we_act ? reg_wdata[NLINES-1:0] : '0);
  end

  // output byte holding stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_line  <= '0;
      out_data  <= '0;
    end else if (done) begin
      out_valid <= 1'b1;
      out_line  <= fline;
      out_data  <= mem_rdata;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign irq = ti_q && tie_q;

  always_comb begin
    reg_rdata = '0;
    case (regsel_e'(reg_sel))
      SEL_CTRL: begin
        reg_rdata[LW-1:0]          = sel_q;
        reg_rdata[CTL_EXT +: EXTW] = ext_q;
        reg_rdata[CTL_TIE]         = tie_q;
        reg_rdata[CTL_TI]          = ti_q;
        reg_rdata[CTL_NXM]         = nxm_q;
      end
      SEL_ADDR: reg_rdata = addr_host;
      SEL_CNT:  reg_rdata = 16'(cnt_host);
      default:  reg_rdata = 16'(active_q);
    endcase
  end
endmodule

// File: rtl/txdma_seq_chk.sv
module txdma_seq_chk #(
  parameter int TMO = 32,
  parameter int LW  = 4,
  parameter int DW  = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_ack,
  input logic          out_valid,
  input logic          out_ready,
  input logic [LW-1:0] out_line,
  input logic [DW-1:0] out_data
);
  localparam int WW = $clog2(TMO + 1) + 1;
  logic [WW-1:0] wait_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 wait_c <= '0;
    else if (mem_req && !mem_ack) wait_c <= wait_c + 1'b1;
    else                        wait_c <= '0;
  end

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && (int'(wait_c) < TMO - 1) |=> mem_req);

  // R9
  tmo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (int'(wait_c) < TMO));

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_line));

  // R5
  no_fetch_while_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !mem_req);

  // R4
  ack_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> out_valid);
endmodule

bind txdma_seq txdma_seq_chk #(.TMO(TMO), .LW($clog2(NLINES)), .DW(DW)) i_txdma_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_req   (mem_req),
  .mem_ack   (mem_ack),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_line  (out_line),
  .out_data  (out_data)
);

// File: tb/test_txdma_seq.sv
`timescale 1ns/1ps
module test_txdma_seq;
  localparam int TMO = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        mem_req;
  logic [17:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [7:0]  mem_rdata = 8'd0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [3:0]  out_line;
  logic [7:0]  out_data;
  logic        irq;

  txdma_seq i_txdma_seq (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_line(out_line),
    .out_data(out_data), .irq(irq)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cycles = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int m_caddr[16], m_cnt[16];
  int m_act, m_ti, m_tie, m_nxm, m_sel, m_ext;
  int m_st, m_line, m_last, m_tcnt, m_ov, m_od, m_ol;
  int nbytes[16];
  int nfetch;
  int order[$];

  function automatic int dof(input int a);
    return ((a * 7 + 3) ^ (a >> 8)) & 255;
  endfunction

  function automatic int mread(input int s);
    case (s)
      0: return (m_ti << 15) | (m_tie << 13) | (m_nxm << 10) | (m_ext << 4) | m_sel;
      1: return m_caddr[m_sel] & 16'hffff;
      2: return m_cnt[m_sel];
      default: return m_act;
    endcase
  endfunction

  always @(posedge clk) begin
    int ack_, tmo_, lastb, L, o_act, o_ov, o_sel, w, s, clr;
    cycles++;
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin m_caddr[i] = 0; m_cnt[i] = 0; end
      m_act = 0; m_ti = 0; m_tie = 0; m_nxm = 0; m_sel = 0; m_ext = 0;
      m_st = 0; m_line = 0; m_last = 15; m_tcnt = 0; m_ov = 0; m_od = 0; m_ol = 0;
    end else begin
      L = m_line; o_act = m_act; o_ov = m_ov; o_sel = m_sel;
      w = int'(reg_wdata); s = int'(reg_sel);
      ack_  = (m_st == 1 && mem_ack) ? 1 : 0;
      tmo_  = (m_st == 1 && !mem_ack && m_tcnt == TMO - 1) ? 1 : 0;
      lastb = (ack_ && m_cnt[L] == 16'hffff) ? 1 : 0;
      if (m_ov && out_ready) begin nbytes[m_ol]++; order.push_back(m_ol); end
      if (ack_) nfetch++;
      // pointer / counter
      if (reg_we && s == 1) m_caddr[o_sel] = (m_ext << 16) | w;
      else if (ack_) m_caddr[L] = (m_caddr[L] + 1) % (1 << 18);
      if (reg_we && s == 2) m_cnt[o_sel] = w;
      else if (ack_) m_cnt[L] = (m_cnt[L] + 1) % 65536;
      if (reg_we && s == 1 && o_sel == L && ack_) ; // host value kept
      // control
      if (lastb) m_ti = 1;
      else if (reg_we && s == 0 && !w[15]) m_ti = 0;
      if (tmo_) m_nxm = 1;
      else if (reg_we && s == 0 && w[8]) m_nxm = 0;
      if (reg_we && s == 0) begin
        m_sel = w & 15; m_ext = (w >> 4) & 3; m_tie = (w >> 13) & 1;
      end
      clr = (lastb || tmo_) ? (1 << L) : 0;
      m_act = (o_act & ~clr) | ((reg_we && s == 3) ? w : 0);
      // output
      if (ack_) begin
        m_ov = 1; m_ol = L; m_od = dof(m_caddr[L] == 0 && 0 ? 0 : ((m_caddr[L] - 1 + (1 << 18)) % (1 << 18)));
        if (reg_we && s == 1 && o_sel == L) m_od = dof(int'(mem_addr));
      end else if (out_ready) m_ov = 0;
      // sequencer
      if (m_st == 0) begin
        if (!o_ov && o_act != 0) begin
          for (int i = 1; i <= 16; i++) begin
            int idx;
            idx = (m_last + i) % 16;
            if (o_act[idx]) begin
              m_line = idx; m_last = idx; m_st = 1; m_tcnt = 0;
              break;
            end
          end
        end
      end else begin
        if (ack_ || tmo_) m_st = 0;
        else m_tcnt++;
      end
    end
  end

  // ---------------- memory, ready driver and per-cycle compare ----------------
  int lat = 0, age = 0, rdy_mode = 0, lfsr = 16'hACE1, run = 0, max_run = 0;
  bit grab = 0;
  int grabbed = 0;

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      chk(mem_req === (m_st == 1), "R4", "mem_req", mem_req, m_st);
      if (m_st == 1) chk(int'(mem_addr) == m_caddr[m_line], "R4", "mem_addr", mem_addr, m_caddr[m_line]);
      chk(out_valid === (m_ov == 1), "R5", "out_valid", out_valid, m_ov);
      if (m_ov == 1) begin
        chk(int'(out_line) == m_ol, "R6", "out_line", out_line, m_ol);
        chk(int'(out_data) == m_od, "R5", "out_data", out_data, m_od);
      end
      chk(irq === (m_ti == 1 && m_tie == 1), "R7", "irq", irq, m_ti & m_tie);
      chk(int'(reg_rdata) == mread(int'(reg_sel)), "R1", "reg_rdata", reg_rdata, mread(int'(reg_sel)));
    end
    if (mem_req) begin
      run++;
      if (run > max_run) max_run = run;
      if (grab) begin grabbed = int'(mem_addr); grab = 0; end
    end else run = 0;
    if (!mem_req) begin age = 0; mem_ack = 1'b0; end
    else begin
      if (!mem_addr[17] && age >= lat) begin
        mem_ack = 1'b1; mem_rdata = 8'(dof(int'(mem_addr)));
      end else mem_ack = 1'b0;
      age++;
    end
    lfsr = ((lfsr >> 1) ^ ((lfsr & 1) ? 16'hB400 : 0)) & 16'hffff;
    out_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? lfsr[0] : 1'b0;
  end

  // ---------------- stimulus ----------------
  task automatic wr(input int s, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 2'(s); reg_wdata = 16'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int s, input int exp, input string req, input string what);
    @(negedge clk);
    reg_we = 1'b0; reg_sel = 2'(s);
    #1;
    chk(int'(reg_rdata) == exp, req, what, reg_rdata, exp);
  endtask

  task automatic setup(input int l, input int ext, input int addr, input int n);
    wr(0, 16'h8000 | (1 << 13) | (ext << 4) | l);
    wr(1, addr);
    wr(2, (-n) & 16'hffff);
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (m_act == 0 && m_ov == 0 && m_st == 0) break;
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (cycles > 150000) begin
      chk(0, "WDOG", "watchdog expired", cycles, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int f0;
    for (int i = 0; i < 16; i++) nbytes[i] = 0;
    nfetch = 0;
    cyc(4);
    rst_n = 1'b1;
    // R11 reset state
    for (int s = 0; s < 4; s++) rd(s, 0, "R11", "reset register");
    chk(!mem_req && !out_valid && !irq, "R11", "reset outputs", {mem_req, out_valid, irq}, 0);

    // R3/R4 single line, four bytes
    lat = 0; rdy_mode = 0;
    setup(3, 0, 16'h0100, 4);
    wr(3, 1 << 3);
    wait_idle();
    rd(3, 0, "R3", "active after finish");
    rd(0, 16'h8000 | (1 << 13) | 3, "R3", "ctrl flag set");
    chk(irq === 1'b1, "R7", "irq after finish", irq, 1);
    rd(1, 16'h0104, "R4", "pointer advanced");
    rd(2, 0, "R3", "counter at zero");
    chk(nbytes[3] == 4, "R3", "bytes on line 3", nbytes[3], 4);

    // R7 flag write semantics
    wr(0, 16'h8000 | (1 << 13) | 3);
    chk(irq === 1'b1, "R7", "write 1 keeps flag", irq, 1);
    wr(0, (1 << 13) | 3);
    chk(irq === 1'b0, "R7", "write 0 clears flag", irq, 0);

    // R6 rotation across three lines with back-pressure
    lat = 2; rdy_mode = 1;
    setup(15, 0, 16'h1000, 3);
    setup(5, 0, 16'h2000, 2);
    setup(0, 0, 16'h3000, 3);
    order.delete();
    wr(3, (1 << 15) | (1 << 5) | 1);
    wait_idle();
    begin
      int exp_o[8] = '{5, 15, 0, 5, 15, 0, 15, 0};
      chk(order.size() == 8, "R6", "byte total", order.size(), 8);
      for (int i = 0; i < 8 && i < order.size(); i++)
        chk(order[i] == exp_o[i], "R6", "service order", order[i], exp_o[i]);
    end

    // R2 upper address bits
    lat = 0; rdy_mode = 0;
    setup(2, 1, 16'hFFFE, 2);
    grab = 1;
    wr(3, 1 << 2);
    wait_idle();
    chk(grabbed == 18'h1FFFE, "R2", "first address", grabbed, 18'h1FFFE);
    rd(1, 0, "R2", "pointer low after carry");

    // R8 stop by all-ones counter
    lat = 1;
    setup(7, 0, 16'h0200, 100);
    wr(3, 1 << 7);
    for (int k = 0; k < 2000 && nbytes[7] < 5; k++) @(negedge clk);
    wr(2, 16'hFFFF);
    wait_idle();
    chk(nbytes[7] >= 5 && nbytes[7] <= 8, "R8", "bytes before stop", nbytes[7], 6);
    rd(1, 16'h0200 + nbytes[7], "R8", "stop pointer");

    // R9 timeout
    max_run = 0;
    setup(9, 2, 16'h0000, 3);
    wr(3, 1 << 9);
    wait_idle();
    chk(max_run == TMO, "R9", "request length", max_run, TMO);
    chk(nbytes[9] == 0, "R9", "no byte on fault", nbytes[9], 0);
    rd(3, 0, "R9", "active cleared on fault");
    begin
      int c;
      c = mread(0);
      chk(c[10] == 1, "R9", "fault bit model", c, 1 << 10);
    end
    rd(0, mread(0), "R9", "fault bit set");
    wr(0, 16'h8000 | (1 << 13) | 9);
    rd(0, mread(0) | (1 << 10), "R9", "fault survives plain write");
    wr(0, 16'h8100 | (1 << 13) | 9);
    rd(0, 16'h8000 & mread(0) | (1 << 13) | 9, "R9", "fault cleared");

    // R10 / R5 set-only mask under full back-pressure
    rdy_mode = 2; lat = 0;
    setup(4, 0, 16'h0300, 5);
    f0 = nfetch;
    wr(3, 1 << 4);
    cyc(20);
    chk(nfetch - f0 == 1, "R5", "one fetch while blocked", nfetch - f0, 1);
    wr(3, 0);
    rd(3, 1 << 4, "R10", "zero write ignored");
    rdy_mode = 0;
    wait_idle();
    chk(nbytes[4] == 5, "R10", "line 4 completes", nbytes[4], 5);

    // R1 windows stay per line
    wr(0, 16'h8000 | (1 << 13) | 3);
    rd(1, 16'h0104, "R1", "line 3 pointer");
    wr(0, 16'h8000 | (1 << 13) | 7);
    rd(1, 16'h0200 + nbytes[7], "R1", "line 7 pointer");

    cyc(5);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule